// File: doc/BRIEF.md
# Pro-Rated Tag Range Allocator

This block splits a fixed pool of context tags on one link among up to eight functions. Each function asks for some number of tags. On a start strobe the block adds up all the requests. If the pool can cover that total, every function gets exactly what it asked for. If it cannot, each function gets a share in proportion to its request, rounded down.

The granted ranges are placed one after another with no gaps, working from function 0 upward. Each function then sees a base tag and a tag count. The allocation runs once after reset. A start strobe that arrives while the block is computing, or after it has finished, leaves the stored result unchanged. A new allocation needs a synchronous reset first.

The computation is sequential. Functions are visited one per step. A shared iterative divider works out any proportional share, so a scaled grant takes extra cycles.

Top module: `tagalloc_top`

## Requirements
- R1: The request of function i sits in `req_i[i*12 +: 12]`. When the sum of all eight requests is 64 or less, function i is granted a count equal to its request.
- R2: When the sum of all eight requests exceeds 64, function i is granted floor(64 * request_i / sum).
- R3: Functions are handled in ascending index order. Function i reports its base in `base_o[i*7 +: 7]` and its count in `cnt_o[i*7 +: 7]`. Each function with a nonzero request gets a base equal to the sum of the counts granted to all lower-index functions, so the first such function starts at 0.
- R4: A function whose request is zero is skipped. It reports base 0 and count 0, and the running start position does not advance.
- R5: A function whose request is nonzero but whose scaled grant truncates to zero still takes the current running start as its base, with count 0. The running start is unchanged.
- R6: `warn_o` rises when the running start after a grant reaches 64 or more. It stays high until reset.
- R7: A start strobe received while an allocation is in progress, or after `done_o` is set, has no effect. The requests captured at the accepted start are used, and the stored bases and counts do not change.
- R8: A synchronous reset clears `done_o`, `warn_o` and every base and count to zero.
- R9: `done_o` is low during the allocation. It rises one cycle after the last function has been handled and stays high until reset.
- R10: No granted count exceeds its request, and the sum of all granted counts never exceeds 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an allocation using the current requests |
| req_i | input | 96 | Eight 12-bit tag requests, function i at bits i*12 +: 12 |
| base_o | output | 56 | Eight 7-bit range bases, function i at bits i*7 +: 7 |
| cnt_o | output | 56 | Eight 7-bit granted counts, function i at bits i*7 +: 7 |
| done_o | output | 1 | Allocation complete, held until reset |
| warn_o | output | 1 | Running start reached or passed the pool size |

## Verification
The assertions check the following on every cycle:
- A committed grant never comes from a zero request and never exceeds the request it serves.
- A start in the finished state leaves the controller idle.
- `done_o` and `warn_o` are sticky, and the stored ranges stay frozen once done is set.
- The divider keeps its remainder below its divisor while the divisor stays stable.

Some properties need a whole allocation to compare against: the actual proportional values, the back-to-back packing, the zero-count-but-nonzero-request base, and the exact moment the warning trips. The bench scenarios show these by running reference arithmetic over complete request sets:
- small totals
- exactly 64
- heavy and lopsided scaling
- all-zero and all-maximum requests

// File: rtl/tagalloc_pkg.sv
package tagalloc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DIV  = 2'd2,
    ST_FIN  = 2'd3
  } alloc_state_e;

endpackage

// File: rtl/tagalloc_sum.sv
module tagalloc_sum #(
  parameter int NUM_FN = 8,
  parameter int REQ_W  = 12,
  localparam int SUM_W = REQ_W + $clog2(NUM_FN)
) (
  input  logic [NUM_FN*REQ_W-1:0] req_flat,
  output logic [SUM_W-1:0]        total
);

  // widen each request before adding so the total cannot wrap
  function automatic logic [SUM_W-1:0] add_all(input logic [NUM_FN*REQ_W-1:0] v);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_FN; i++) begin
      acc = acc + SUM_W'(v[i*REQ_W +: REQ_W]);
    end
    return acc;
  endfunction

  always_comb total = add_all(req_flat);

endmodule

// File: rtl/tagalloc_div.sv
module tagalloc_div #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 15,
  localparam int CNT_W = $clog2(NUM_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             busy,
  output logic             fin,
  output logic [NUM_W-1:0] quot
);

  logic [NUM_W-1:0] work_q;
  logic [DEN_W-1:0] rem_q;
  logic [CNT_W-1:0] step_q;
  logic [DEN_W:0]   trial;
  logic             take;
  logic [DEN_W-1:0] rem_next;

  // one restoring step: bring down the next dividend bit, subtract if it fits
  always_comb begin
    trial    = {rem_q, work_q[NUM_W-1]};
    take     = trial >= {1'b0, denom};
    rem_next = take ? DEN_W'(trial - {1'b0, denom}) : DEN_W'(trial);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      work_q <= '0;
      rem_q  <= '0;
      step_q <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        busy   <= 1'b1;
        work_q <= numer;
        rem_q  <= '0;
        step_q <= '0;
      end else if (busy) begin
        rem_q  <= rem_next;
        work_q <= {work_q[NUM_W-2:0], take};
        step_q <= step_q + 1'b1;
        if (step_q == CNT_W'(NUM_W - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quot = work_q;

  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem_q < denom)); // R2

  AST_DIV_DEN_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(denom)); // R2

endmodule

// File: rtl/tagalloc_store.sv
module tagalloc_store #(
  parameter int NUM_FN = 8,
  parameter int CW     = 7,
  localparam int IW    = $clog2(NUM_FN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [CW-1:0]        wr_base,
  input  logic [CW-1:0]        wr_cnt,
  output logic [NUM_FN*CW-1:0] base_flat,
  output logic [NUM_FN*CW-1:0] cnt_flat
);

  for (genvar g = 0; g < NUM_FN; g++) begin : g_slot
    logic [CW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic          hit;
    assign hit = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        cnt_q  <= '0;
      end else if (hit) begin
        base_q <= wr_base;
        cnt_q  <= wr_cnt;
      end
    end

    assign base_flat[g*CW +: CW] = base_q;
    assign cnt_flat[g*CW +: CW]  = cnt_q;
  end

endmodule

// File: rtl/tagalloc_top.sv
module tagalloc_top
  import tagalloc_pkg::*;
#(
  parameter int NUM_FN = 8,
  parameter int POOL   = 64,
  parameter int REQ_W  = 12,
  localparam int CW     = $clog2(POOL + 1),
  localparam int IW     = $clog2(NUM_FN),
  localparam int SUM_W  = REQ_W + $clog2(NUM_FN),
  localparam int PROD_W = REQ_W + $clog2(POOL)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [NUM_FN*REQ_W-1:0] req_i,
  output logic [NUM_FN*CW-1:0]    base_o,
  output logic [NUM_FN*CW-1:0]    cnt_o,
  output logic                    done_o,
  output logic                    warn_o
);

  alloc_state_e     state_q;
  logic [REQ_W-1:0] req_q [NUM_FN];
  logic [SUM_W-1:0] total_q;
  logic [SUM_W-1:0] total_now;
  logic [IW-1:0]    idx_q;
  logic [CW-1:0]    pos_q;
  logic             done_q;
  logic             warn_q;

  // named events for the assertions
  logic             accept_start;
  logic             wr_en;
  logic [CW-1:0]    wr_cnt;
  logic [REQ_W-1:0] cur_req;
  logic             scale_mode;
  logic             last_fn;
  logic [CW:0]      pos_next;

  logic             div_go;
  logic             div_busy;
  logic             div_fin;
  logic [PROD_W-1:0] div_quot;

  // arithmetic kept in functions so the bench can restate it independently
  function automatic logic [PROD_W-1:0] scaled_numer(input logic [REQ_W-1:0] r);
    return PROD_W'(r) * PROD_W'(POOL);
  endfunction

  function automatic logic needs_scaling(input logic [SUM_W-1:0] t);
    return t > SUM_W'(POOL);
  endfunction

  function automatic logic [CW:0] advance(input logic [CW-1:0] p, input logic [CW-1:0] g);
    return {1'b0, p} + {1'b0, g};
  endfunction

  tagalloc_sum #(.NUM_FN(NUM_FN), .REQ_W(REQ_W)) i_sum (
    .req_flat (req_i),
    .total    (total_now)
  );

  tagalloc_div #(.NUM_W(PROD_W), .DEN_W(SUM_W)) i_div (
    .clk   (clk),
    .rst   (rst),
    .go    (div_go),
    .numer (scaled_numer(cur_req)),
    .denom (total_q),
    .busy  (div_busy),
    .fin   (div_fin),
    .quot  (div_quot)
  );

  tagalloc_store #(.NUM_FN(NUM_FN), .CW(CW)) i_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (idx_q),
    .wr_base   (pos_q),
    .wr_cnt    (wr_cnt),
    .base_flat (base_o),
    .cnt_flat  (cnt_o)
  );

  always_comb begin
    cur_req      = req_q[idx_q];
    scale_mode   = needs_scaling(total_q);
    last_fn      = idx_q == IW'(NUM_FN - 1);
    accept_start = (state_q == ST_IDLE) && start_i && !done_q;
    wr_en        = 1'b0;
    wr_cnt       = '0;
    div_go       = 1'b0;
    if (state_q == ST_SCAN && cur_req != '0) begin
      if (scale_mode) begin
        div_go = 1'b1;
      end else begin
        wr_en  = 1'b1;
        wr_cnt = CW'(cur_req);
      end
    end else if (state_q == ST_DIV && div_fin) begin
      wr_en  = 1'b1;
      wr_cnt = CW'(div_quot);
    end
    pos_next = advance(pos_q, wr_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      total_q <= '0;
      idx_q   <= '0;
      pos_q   <= '0;
      done_q  <= 1'b0;
      warn_q  <= 1'b0;
      for (int i = 0; i < NUM_FN; i++) req_q[i] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            for (int i = 0; i < NUM_FN; i++) req_q[i] <= req_i[i*REQ_W +: REQ_W];
            total_q <= total_now;
            idx_q   <= '0;
            pos_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN, ST_DIV: begin
          if (wr_en) begin
            pos_q <= pos_next[CW-1:0];
            if (pos_next >= (CW+1)'(POOL)) warn_q <= 1'b1;
          end
          if (state_q == ST_SCAN && div_go) begin
            state_q <= ST_DIV;
          end else if (state_q == ST_SCAN || wr_en) begin
            if (last_fn) begin
              state_q <= ST_FIN;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_SCAN;
            end
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign warn_o = warn_q;

  AST_NO_ZERO_GRANT_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cur_req != '0)); // R4

  AST_GRANT_WITHIN_REQ: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (REQ_W'(wr_cnt) <= cur_req)); // R10

  AST_START_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && done_q && start_i) |=> (state_q == ST_IDLE)); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o); // R9

  AST_RANGES_FROZEN: assert property (@(posedge clk) disable iff (rst)
    done_o |=> ($stable(base_o) && $stable(cnt_o))); // R7

  AST_WARN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    warn_o |=> warn_o); // R6

  AST_POOL_BOUND: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (pos_next <= (CW+1)'(POOL))); // R10

endmodule

// File: tb/test_tagalloc_top.sv
module test_tagalloc_top;

  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int RW = 12;
  localparam int CWB = 7;
  localparam int POOLB = 64;

  typedef struct {
    int fn;
    int base;
    int cnt;
    int req;
    bit warn;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [NF*RW-1:0] req_i = '0;
  logic [NF*CWB-1:0] base_o;
  logic [NF*CWB-1:0] cnt_o;
  logic done_o;
  logic warn_o;

  int errors = 0;
  int checks = 0;
  exp_t sb_q[$];
  int last_base [NF];
  int last_cnt  [NF];
  bit last_warn;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagalloc_top i_tagalloc_top (
    .clk(clk), .rst(rst), .start_i(start_i), .req_i(req_i),
    .base_o(base_o), .cnt_o(cnt_o), .done_o(done_o), .warn_o(warn_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R8 done after reset", done_o, 0);
    check("R8 warn after reset", warn_o, 0);
    for (int f = 0; f < NF; f++) begin
      check("R8 base after reset", base_o[f*CWB +: CWB], 0);
      check("R8 count after reset", cnt_o[f*CWB +: CWB], 0);
    end
  endtask

  // reference model written from the requirements
  task automatic push_expected(input int r [NF]);
    int total = 0;
    int pos = 0;
    bit w = 0;
    int g;
    for (int f = 0; f < NF; f++) total += r[f];
    for (int f = 0; f < NF; f++) begin
      if (r[f] == 0) begin
        last_base[f] = 0;
        last_cnt[f]  = 0;
      end else begin
        g = (total <= POOLB) ? r[f] : (POOLB * r[f]) / total;
        last_base[f] = pos;
        last_cnt[f]  = g;
        pos += g;
        if (pos >= POOLB) w = 1;
      end
    end
    last_warn = w;
    for (int f = 0; f < NF; f++)
      sb_q.push_back('{fn: f, base: last_base[f], cnt: last_cnt[f], req: r[f], warn: w});
  endtask

  task automatic load_req(input int r [NF]);
    for (int f = 0; f < NF; f++) req_i[f*RW +: RW] = RW'(r[f]);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_case(input int r [NF], input bit busy_restart, input bit check_early);
    int alt [NF];
    do_reset();
    load_req(r);
    push_expected(r);
    pulse_start();
    if (check_early) check("R9 done low while busy", done_o, 0);
    if (busy_restart) begin
      repeat (3) @(negedge clk);
      for (int f = 0; f < NF; f++) alt[f] = 9 + f;
      load_req(alt);
      pulse_start();   // R7: ignored while computing
    end
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: on done rising, pop and compare every expected slot
  initial begin
    bit armed = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (done_o && !armed && !rst) begin
        armed = 1'b1;
        check("R9 done raised", done_o, 1);
        while (sb_q.size() != 0) begin
          e = sb_q.pop_front();
          check("R3 base packed", base_o[e.fn*CWB +: CWB], e.base);
          if (e.req == 0) check("R4 zero request count", cnt_o[e.fn*CWB +: CWB], 0);
          else check("R1 R2 R5 granted count", cnt_o[e.fn*CWB +: CWB], e.cnt);
          check("R10 grant within request", cnt_o[e.fn*CWB +: CWB] <= e.req, 1);
          if (e.fn == 0) check("R6 warn flag", warn_o, e.warn);
        end
      end
      if (!done_o) armed = 1'b0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r_small [NF] = '{3, 0, 5, 1, 0, 0, 2, 7};        // R1
    int r_exact [NF] = '{8, 8, 8, 8, 8, 8, 8, 8};        // R1 R6 at 64
    int r_scale [NF] = '{100, 50, 0, 25, 0, 0, 0, 25};   // R2 R4
    int r_lop   [NF] = '{4095, 1, 0, 0, 0, 0, 0, 3};     // R5
    int r_zero  [NF] = '{0, 0, 0, 0, 0, 0, 0, 0};        // R4
    int r_max   [NF] = '{4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095};
    int r_odd   [NF] = '{7, 30, 0, 19, 11, 0, 40, 2};    // R2
    int r_other [NF] = '{1, 1, 1, 1, 1, 1, 1, 1};

    run_case(r_small, 1'b0, 1'b1);
    run_case(r_exact, 1'b0, 1'b0);
    run_case(r_scale, 1'b1, 1'b1);
    run_case(r_lop, 1'b0, 1'b0);
    run_case(r_zero, 1'b0, 1'b0);
    run_case(r_max, 1'b0, 1'b0);
    run_case(r_odd, 1'b0, 1'b0);

    // R7: start after done changes nothing
    load_req(r_other);
    pulse_start();
    repeat (40) @(negedge clk);
    check("R7 done kept", done_o, 1);
    check("R7 warn kept", warn_o, last_warn);
    for (int f = 0; f < NF; f++) begin
      check("R7 base unchanged", base_o[f*CWB +: CWB], last_base[f]);
      check("R7 count unchanged", cnt_o[f*CWB +: CWB], last_cnt[f]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule